// File: doc/BRIEF.md
# Addressed Serial Attenuation Register

This block is the device-side serial control port of a digitally stepped attenuator. A host shifts a 16-bit frame into it over three wires (data, clock, latch enable). The low byte of the frame is the attenuation word and the high byte is an address. When latch enable rises, the block checks the low three address bits against three static strap inputs. Only a match copies the attenuation word into the stored setting. Up to eight such blocks can therefore share one set of serial wires, each answering to its own strap value.

The stored word holds a 7-bit attenuation code, in quarter-decibel units (the code is the dB setting times four), plus a reserved top bit. Host software must write that top bit as zero. Reset loads the word with every bit set, which is full attenuation with the reserved bit high. A sticky status flag reports whether an accepted write has cleared the reserved bit since reset. A parallel control path may be handed control only after that has happened.

All three serial wires are asynchronous to the block. Each passes through a multi-flop synchronizer into a fast system clock, and the block finds the serial-clock and latch-enable edges there. The system clock must run at least eight times faster than the serial clock.

Top module: `ser_atten_reg`

## Requirements
- R1: After reset the code output is all ones (0x7F), the reserved-bit output is 1 and the cleared-status output is 0.
- R2: Each rising edge of the serial clock shifts the serial data bit into a 16-bit frame, least significant bit first. After 16 edges, frame bits 7..0 hold the attenuation word (bit 7 is the reserved bit) and frame bits 15..8 hold the address byte.
- R3: On a rising edge of latch enable, the stored word takes the attenuation word when frame bits 10..8 equal the straps. Frame bits 15..11 are ignored.
- R4: A latch enable rising edge whose address bits 10..8 differ from the straps leaves the stored word unchanged.
- R5: Serial clock edges with latch enable low never change the outputs.
- R6: Serial clock edges while latch enable is high still shift the frame, but the stored word changes only on the next rising edge of latch enable.
- R7: The reserved-bit output mirrors the stored top bit. The cleared-status output becomes 1 when an accepted write stores a 0 there and stays 1 until reset, even if a later write sets the bit again.
- R8: After latch enable rises ahead of a system clock edge, the outputs take the new word on the third system clock edge, counting that first edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_le_i | input | 1 | Latch enable, asynchronous |
| strap_i | input | STRAP_W (3) | Static device address straps |
| atten_code_o | output | CODE_W (7) | Stored attenuation code, quarter-dB units |
| rsvd_bit_o | output | 1 | Stored reserved top bit |
| rsvd_cleared_o | output | 1 | Sticky flag: reserved bit has been cleared since reset |

## Verification
The bench builds the block with its default parameters: a 7-bit code, an 8-bit address field, three straps, two synchronizer stages and address checking switched on. With those values its reference model can predict the exact cycle in which the synchronized serial-clock and latch-enable edges take effect. Every frame position and the full mismatch and upper-bits-ignored address space become reachable with a handful of frames. Changing the strap value partway through the run shows that the compare follows the straps and is not fixed at one address.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

   // width of the address byte that follows the attenuation word
   localparam int ADDR_FIELD_W_DEF = 8;

   // minimum number of flops for a safe synchronizer
   localparam int MIN_SYNC_STAGES = 2;

   function automatic int frame_width(input int code_w, input int addr_w);
      return code_w + 1 + addr_w;
   endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level_o,
   output logic rise_o
);
   import atten_ser_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("sync_edge: STAGES below minimum");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;

   // a detected edge lasts one system clock
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] frame_o
);
   if (FRAME_W < 2) begin : g_bad_frame
      $error("frame_shifter: FRAME_W too small");
   end

   logic [FRAME_W-1:0] sreg_q;

   // new bits enter at the top, so the first bit ends at position 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sreg_q <= '0;
      else if (shift_en) sreg_q <= {bit_i, sreg_q[FRAME_W-1:1]};
   end

   assign frame_o = sreg_q;

   a_r2_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (frame_o == {$past(bit_i), $past(frame_o[FRAME_W-1:1])}));

   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(frame_o));

endmodule

// File: rtl/addr_word_store.sv
module addr_word_store #(
   parameter int WORD_W       = 8,
   parameter int ADDR_FIELD_W = 8,
   parameter int STRAP_W      = 3,
   parameter bit CHECK_ADDR   = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           latch_i,
   input  logic [WORD_W+ADDR_FIELD_W-1:0] frame_i,
   input  logic [STRAP_W-1:0]             strap_i,
   output logic [WORD_W-1:0]              word_o,
   output logic                           cleared_o
);
   localparam int TOP = WORD_W - 1;

   if (STRAP_W > ADDR_FIELD_W) begin : g_bad_strap
      $error("addr_word_store: more straps than address bits");
   end

   logic                  match;
   logic                  upd_en;
   logic [WORD_W-1:0]     new_word;
   logic [STRAP_W-1:0]    rx_addr;

   assign new_word = frame_i[WORD_W-1:0];
   assign rx_addr  = frame_i[WORD_W +: STRAP_W];

   if (CHECK_ADDR) begin : g_addr_check
      assign match = (rx_addr == strap_i);
   end else begin : g_addr_any
      assign match = 1'b1;
   end

   assign upd_en = latch_i & match;

   logic [WORD_W-1:0] word_q;
   logic              cleared_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q    <= '1;
         cleared_q <= 1'b0;
      end else if (upd_en) begin
         word_q <= new_word;
         if (!new_word[TOP]) cleared_q <= 1'b1;
      end
   end

   assign word_o    = word_q;
   assign cleared_o = cleared_q;

   a_r3_take_word: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (word_o == $past(new_word)));

   a_r4_keep_word: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(word_o));

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cleared_o |=> cleared_o);

   a_r7_cleared_seen: assert property (@(posedge clk) disable iff (!rst_n)
      !word_o[TOP] |-> cleared_o);

endmodule

// File: rtl/ser_atten_reg.sv
module ser_atten_reg #(
   parameter int CODE_W       = 7,
   parameter int ADDR_FIELD_W = 8,
   parameter int STRAP_W      = 3,
   parameter int SYNC_STAGES  = 2,
   parameter bit CHECK_ADDR   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_data_i,
   input  logic               ser_clk_i,
   input  logic               ser_le_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic [CODE_W-1:0]  atten_code_o,
   output logic               rsvd_bit_o,
   output logic               rsvd_cleared_o
);
   import atten_ser_pkg::*;

   localparam int WORD_W  = CODE_W + 1;
   localparam int FRAME_W = frame_width(CODE_W, ADDR_FIELD_W);

   if (CODE_W < 1) begin : g_bad_code
      $error("ser_atten_reg: CODE_W must be positive");
   end

   logic data_lvl, data_rise;
   logic sclk_lvl, sclk_rise;
   logic le_lvl,   le_rise;

   sync_edge #(.STAGES(SYNC_STAGES)) u_sync_data (
      .clk(clk), .rst_n(rst_n), .din(ser_data_i),
      .level_o(data_lvl), .rise_o(data_rise));

   sync_edge #(.STAGES(SYNC_STAGES)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .din(ser_clk_i),
      .level_o(sclk_lvl), .rise_o(sclk_rise));

   sync_edge #(.STAGES(SYNC_STAGES)) u_sync_le (
      .clk(clk), .rst_n(rst_n), .din(ser_le_i),
      .level_o(le_lvl), .rise_o(le_rise));

   logic [FRAME_W-1:0] frame;

   frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise),
      .bit_i(data_lvl), .frame_o(frame));

   logic [WORD_W-1:0] word;
   logic              cleared;

   addr_word_store #(
      .WORD_W(WORD_W), .ADDR_FIELD_W(ADDR_FIELD_W),
      .STRAP_W(STRAP_W), .CHECK_ADDR(CHECK_ADDR)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .latch_i(le_rise), .frame_i(frame),
      .strap_i(strap_i), .word_o(word), .cleared_o(cleared));

   assign atten_code_o   = word[CODE_W-1:0];
   assign rsvd_bit_o     = word[WORD_W-1];
   assign rsvd_cleared_o = cleared;

   // unused level / data-edge outputs are tied off into a reduction
   logic unused_ok;
   assign unused_ok = &{1'b0, data_rise, sclk_lvl, le_lvl};

   // outputs move only in the cycle after a detected latch edge
   a_r5_quiet_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> ($stable(atten_code_o) && $stable(rsvd_bit_o)));

endmodule

// File: tb/ser_atten_reg_tb_top.sv
module ser_atten_reg_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCLK  = 4;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sd = 1'b0, sc = 1'b0, le = 1'b0;
   logic [2:0] strap = 3'b101;
   logic [6:0] code;
   logic       rsvd, clrd;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ser_atten_reg dut_i (
      .clk(clk), .rst_n(rst_n), .ser_data_i(sd), .ser_clk_i(sc),
      .ser_le_i(le), .strap_i(strap), .atten_code_o(code),
      .rsvd_bit_o(rsvd), .rsvd_cleared_o(clrd));

   // behavioural reference: input histories, integer frame, stored byte
   int hd[4], hc[4], hl[4];
   int m_frame, m_word, m_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin hd[i] = 0; hc[i] = 0; hl[i] = 0; end
         m_frame = 0; m_word = 255; m_clr = 0;
      end else begin
         for (int i = 3; i > 0; i--) begin
            hd[i] = hd[i-1]; hc[i] = hc[i-1]; hl[i] = hl[i-1];
         end
         hd[0] = int'(sd); hc[0] = int'(sc); hl[0] = int'(le);
         if (hl[2] == 1 && hl[3] == 0 && ((m_frame >> 8) & 7) == int'(strap)) begin
            m_word = m_frame & 255;
            if (m_word < 128) m_clr = 1;
         end
         if (hc[2] == 1 && hc[3] == 0)
            m_frame = (m_frame >> 1) | (hd[2] << 15);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (int'(code) != (m_word & 127) || int'(rsvd) != (m_word >> 7) ||
             int'(clrd) != m_clr) begin
            errors++;
            $display("FAIL model R3/R4/R7 code=%0h rsvd=%0d clr=%0d exp code=%0h rsvd=%0d clr=%0d",
                     code, rsvd, clrd, m_word & 127, m_word >> 7, m_clr);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_frame(input logic [7:0] addr, input logic [7:0] word);
      logic [15:0] f;
      f = {addr, word};
      for (int i = 0; i < 16; i++) begin
         sd = f[i];
         wait_n(HALF_SCLK);
         sc = 1'b1;
         wait_n(HALF_SCLK);
         sc = 1'b0;
      end
      wait_n(HALF_SCLK);
   endtask

   task automatic pulse_le();
      le = 1'b1;
      wait_n(HALF_SCLK);
      le = 1'b0;
      wait_n(8);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      // R1: reset state
      chk("R1 code", int'(code), 'h7F);
      chk("R1 rsvd", int'(rsvd), 1);
      chk("R1 cleared", int'(clrd), 0);

      // R2 / R5: 18.25 dB at own address, outputs quiet while shifting
      shift_frame(8'h05, 8'h49);
      chk("R5 quiet before latch", int'(code), 'h7F);
      // R8: latency of the latch edge
      le = 1'b1;
      wait_n(1); chk("R8 edge1 old", int'(code), 'h7F);
      wait_n(1); chk("R8 edge2 old", int'(code), 'h7F);
      wait_n(1); chk("R8 edge3 new", int'(code), 'h49);
      le = 1'b0;
      wait_n(8);
      chk("R2 word lsb first", int'(code), 'h49);
      chk("R7 rsvd cleared", int'(rsvd), 0);
      chk("R7 status set", int'(clrd), 1);

      // R4: address mismatch
      shift_frame(8'h03, 8'h10);
      pulse_le();
      chk("R4 mismatch keeps", int'(code), 'h49);

      // R3: upper address bits ignored
      shift_frame(8'hFD, 8'h20);
      pulse_le();
      chk("R3 upper bits ignored", int'(code), 'h20);

      // R7: reserved bit set again, status stays
      shift_frame(8'h05, 8'h85);
      pulse_le();
      chk("R7 code", int'(code), 'h05);
      chk("R7 rsvd mirrors", int'(rsvd), 1);
      chk("R7 status sticky", int'(clrd), 1);

      // R6: shifting with latch enable high
      le = 1'b1;
      wait_n(6);
      shift_frame(8'h05, 8'h33);
      chk("R6 no change while high", int'(code), 'h05);
      le = 1'b0;
      wait_n(6);
      chk("R6 no change on fall", int'(code), 'h05);
      pulse_le();
      chk("R6 next latch takes", int'(code), 'h33);

      // R3 / R4 with different straps
      strap = 3'b010;
      wait_n(4);
      shift_frame(8'h02, 8'h00);
      pulse_le();
      chk("R3 new strap match", int'(code), 'h00);
      shift_frame(8'h05, 8'h7E);
      pulse_le();
      chk("R4 old address rejected", int'(code), 'h00);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule